// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port that sits on a simple memory-mapped request bus. Each pin can be made an input or an output through a direction register. Pin data is reached through an address window in which the address bits themselves choose the pins that an access touches. Software can therefore set or clear a single pin with one write and no read-modify-write. Pins that are inputs are brought into the clock domain through a two-flop synchronizer before they can be read.

A request is presented with `bus_valid` together with `bus_write`, `bus_addr` and `bus_wdata`. The port never applies back-pressure: `bus_ready` is held high, so every cycle with `bus_valid` high is one accepted access. A write takes effect at the edge that accepts it. An accepted read returns its byte on `rd_data` with a `rd_valid` pulse one cycle later. The response path has no ready signal, because the port produces exactly one response per read and the requester must take it.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, `pad_oe` is 0x00, `pad_out` is 0x00 and `rd_valid` is 0, so every pin is an input driving 0.
- R2: Offset 0x400 holds the direction byte, in which bit n set to 1 makes pin n an output. The byte reads back at 0x400, and `pad_oe` shows a written value from the cycle after the write.
- R3: A write to an offset below 0x400 updates output pin n only when address bit n+2 is 1. In other words, address bits [9:2] are the pin mask. Every pin outside the mask keeps its driven value.
- R4: A read from an offset below 0x400 returns 0 in every bit position whose address mask bit (address bit n+2 for pin n) is 0.
- R5: A data write never changes the driven value of a pin whose direction bit is 0 when the write is accepted. After that pin is switched to output, it still drives its earlier value.
- R6: Within the read mask, a data read returns the driven value for an output pin and the synchronized pad level for an input pin.
- R7: A pad level change seen just before clock edge A is returned by a read accepted at the edge after A plus one, which is the third edge from the change. Reads accepted at edges A and A+1 still return the old level.
- R8: Offsets from 0x401 to 0xFFF read as 0x00, and writes to them change neither the direction nor the driven values.
- R9: `bus_ready` is always 1. `rd_valid` is high for exactly the one cycle after each accepted read and stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle |
| rd_data | output | 8 | Read response byte |
| pad_in | input | 8 | Pad levels from the pins (asynchronous) |
| pad_out | output | 8 | Driven output values |
| pad_oe | output | 8 | Per-pin output enable (= direction) |

## Verification
The port produces results on three timescales:
- A write moves `pad_out` or `pad_oe` at its accepting edge, so the bench samples those outputs at the following falling edge.
- A read answers on `rd_data`/`rd_valid` one edge after acceptance, so the bench drops `bus_valid` at the next falling edge and samples the response there.
- A pad change needs two edges through the synchronizer. The bench therefore changes `pad_in` at a falling edge, issues three back-to-back reads, and expects the old level, the old level and then the new level.

In every sweep the pad is held still for more than two cycles before any read, so no check races the synchronizer.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

  // Classification of one bus access by its offset.
  typedef enum logic [1:0] {
    ACC_DATA     = 2'd0,
    ACC_DIR      = 2'd1,
    ACC_UNMAPPED = 2'd2
  } acc_kind_e;

  // Decoded access presented to the register stage.
  typedef struct packed {
    logic      wr_data;
    logic      wr_dir;
    logic      rd;
    acc_kind_e kind;
  } acc_ctl_t;

endpackage

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
  import gpio_mp_pkg::*;
#(
  parameter int unsigned              PIN_COUNT  = 8,
  parameter int unsigned              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]        DIR_OFFSET = 12'h400
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [ADDR_W-1:0]    addr,
  output acc_ctl_t             ctl,
  output logic [PIN_COUNT-1:0] pin_mask
);

  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned MASK_MSB = MASK_LSB + PIN_COUNT - 1;

  acc_kind_e kind;

  always_comb begin
    if (addr < DIR_OFFSET)       kind = ACC_DATA;
    else if (addr == DIR_OFFSET) kind = ACC_DIR;
    else                         kind = ACC_UNMAPPED;
  end

  // Address bits above the byte lane select pins one-for-one.
  assign pin_mask = addr[MASK_MSB:MASK_LSB];

  always_comb begin
    ctl.kind    = kind;
    ctl.rd      = valid && !write;
    ctl.wr_data = valid && write && (kind == ACC_DATA);
    ctl.wr_dir  = valid && write && (kind == ACC_DIR);
  end

endmodule

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
  import gpio_mp_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  acc_ctl_t             ctl,
  input  logic [PIN_COUNT-1:0] pin_mask,
  input  logic [PIN_COUNT-1:0] wdata,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] out_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dir_q <= '0;
    else if (ctl.wr_dir) dir_q <= wdata;
  end

  // A pin's driven value moves only when it is masked in and already an output.
  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    logic take;
    assign take = ctl.wr_data && pin_mask[n] && dir_q[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_q[n] <= 1'b0;
      else if (take) out_q[n] <= wdata[n];
    end
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_mp_pkg::*;
#(
  parameter int unsigned       PIN_COUNT   = 8,
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_OFFSET  = 12'h400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PIN_COUNT-1:0] bus_wdata,
  output logic                 rd_valid,
  output logic [PIN_COUNT-1:0] rd_data,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);

  acc_ctl_t             ctl;
  logic [PIN_COUNT-1:0] pin_mask;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] out_q;
  logic [PIN_COUNT-1:0] pad_sync;
  logic [PIN_COUNT-1:0] pin_level;
  logic [PIN_COUNT-1:0] rd_next;
  logic [PIN_COUNT-1:0] rd_data_q;
  logic                 rd_valid_q;

  gpio_mp_decode #(
    .PIN_COUNT (PIN_COUNT),
    .ADDR_W    (ADDR_W),
    .DIR_OFFSET(DIR_OFFSET)
  ) u_decode (
    .valid   (bus_valid),
    .write   (bus_write),
    .addr    (bus_addr),
    .ctl     (ctl),
    .pin_mask(pin_mask)
  );

  gpio_mp_regs #(
    .PIN_COUNT(PIN_COUNT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .pin_mask(pin_mask),
    .wdata   (bus_wdata),
    .dir_q   (dir_q),
    .out_q   (out_q)
  );

  gpio_mp_sync #(
    .WIDTH (PIN_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(pad_sync)
  );

  // Per-pin level as seen by software: own drive for outputs, pad for inputs.
  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_level
    assign pin_level[n] = dir_q[n] ? out_q[n] : pad_sync[n];
  end

  always_comb begin
    unique case (ctl.kind)
      ACC_DATA: rd_next = pin_level & pin_mask;
      ACC_DIR:  rd_next = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= ctl.rd;
      if (ctl.rd) rd_data_q <= rd_next;
    end
  end

  assign bus_ready = 1'b1;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;

endmodule

// File: rtl/gpio_mp_checker.sv
module gpio_mp_checker #(
  parameter int unsigned       PIN_COUNT  = 8,
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 12'h400
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_ready,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [PIN_COUNT-1:0] bus_wdata,
  input logic                 rd_valid,
  input logic [PIN_COUNT-1:0] rd_data,
  input logic [PIN_COUNT-1:0] pad_out,
  input logic [PIN_COUNT-1:0] pad_oe
);

  logic [PIN_COUNT-1:0] amask;
  logic                 in_win;
  logic                 is_dir;
  logic                 is_rd;

  assign amask  = bus_addr[PIN_COUNT+1:2];
  assign in_win = bus_addr < DIR_OFFSET;
  assign is_dir = bus_addr == DIR_OFFSET;
  assign is_rd  = bus_valid && !bus_write;

  // R9: never back-pressures
  p_always_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);

  // R9: response strobe follows every accepted read
  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);

  // R9: no response without a read
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_valid);

  // R3: pins outside the address mask hold across a data write
  p_unmasked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && in_win)
    |=> ((pad_out ^ $past(pad_out)) & ~$past(amask)) == '0);

  // R5: an input pin's driven value never moves
  p_input_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

  // R4: masked-out positions read as zero
  p_masked_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && in_win) |=> (rd_data & ~$past(amask)) == '0);

  // R8: unmapped offsets read as zero
  p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !in_win && !is_dir) |=> rd_data == '0);

  // R2 and R8: direction changes only through a write to its offset
  p_dir_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && is_dir) |=> $stable(pad_oe));

  // R8: writes elsewhere leave the driven values alone
  p_unmapped_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !in_win) |=> $stable(pad_out));

  // R1: state seen during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_state_r1: assert (pad_oe == '0 && pad_out == '0 && !rd_valid);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

endmodule

bind gpio_masked_port gpio_mp_checker #(
  .PIN_COUNT (PIN_COUNT),
  .ADDR_W    (ADDR_W),
  .DIR_OFFSET(DIR_OFFSET)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/gpio_masked_port_test.sv
`timescale 1ns/1ps
module gpio_masked_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] m_out;
  logic [7:0] m_dir;

  always #10 clk = ~clk;

  gpio_masked_port uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [11:0] win_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    m_out = '0; m_dir = '0;
    @(negedge clk);
    check("R9 ready", {7'd0, bus_ready}, 8'h01);

    // R5: writes to input pins are dropped
    bus_wr(win_addr(8'hFF), 8'hFF);
    check("R5 out unchanged", pad_out, 8'h00);
    check("R9 no rsp after write", {7'd0, rd_valid}, 8'h00);
    bus_wr(12'h400, 8'hFF); m_dir = 8'hFF;
    check("R2 oe follows", pad_oe, 8'hFF);
    bus_rd(win_addr(8'hFF), r);
    check("R5 old value kept", r, 8'h00);
    check("R9 rsp strobe", {7'd0, rd_valid}, 8'h01);
    @(negedge clk);
    check("R9 strobe one cycle", {7'd0, rd_valid}, 8'h00);

    // R3: sweep every pin mask with all pins outputs
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'(m * 37 + 11);
      bus_wr(win_addr(8'(m)), d);
      m_out = (m_out & ~8'(m)) | (d & 8'(m));
      check("R3 masked write", pad_out, m_out);
    end

    // R2: direction read-back
    bus_wr(12'h400, 8'h96);
    check("R2 oe", pad_oe, 8'h96);
    bus_rd(12'h400, r);
    check("R2 readback", r, 8'h96);

    // R5: mixed directions, write to all pins
    bus_wr(win_addr(8'hFF), ~m_out);
    m_out = (m_out & ~8'h96) | (~m_out & 8'h96);
    check("R5 mixed write", pad_out, m_out);

    // R4 and R6: sweep directions and read masks with a steady pad
    pad_in = 8'h5C;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      m_dir = 8'(k * 17);
      bus_wr(12'h400, m_dir);
      for (int m = 0; m < 256; m++) begin
        bus_rd(win_addr(8'(m)), r);
        check("R4 R6 masked read", r, 8'(m) & ((m_dir & m_out) | (~m_dir & pad_in)));
      end
    end

    // R8: unmapped offsets
    bus_wr(12'h400, 8'h3C); m_dir = 8'h3C;
    bus_wr(12'h401, 8'hFF);
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h800, 8'hFF);
    bus_wr(12'hFFF, 8'h00);
    check("R8 dir kept", pad_oe, 8'h3C);
    check("R8 out kept", pad_out, m_out);
    bus_rd(12'h404, r);
    check("R8 read zero 404", r, 8'h00);
    bus_rd(12'hFFF, r);
    check("R8 read zero FFF", r, 8'h00);

    // R7: synchronizer latency, all pins inputs
    bus_wr(12'h400, 8'h00);
    @(negedge clk);
    pad_in = 8'hA5;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = win_addr(8'hFF);
    @(negedge clk);
    check("R7 first read old", r === r ? rd_data : 8'hXX, 8'h5C);
    @(negedge clk);
    check("R7 second read old", rd_data, 8'h5C);
    @(negedge clk);
    check("R7 third read new", rd_data, 8'hA5);
    bus_valid = 1'b0;
    @(negedge clk);
    check("R9 idle", {7'd0, rd_valid}, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule